// File: doc/BRIEF.md
# Bipolar Return-to-Zero Word Serializer

This block accepts a 32-bit word from an upstream source through a valid/ready handshake and sends it out as a three-level return-to-zero stream on a pair of lines. Each bit period has two halves. In the first half the lines carry the bit's level, and in the second half both lines rest at null. After the last bit the lines stay null for a fixed inter-word gap. A one-cycle completion pulse then marks the end of the word, and the block is ready for the next word.

All timing is counted in periods of a 1 MHz reference tick that arrives as a clock enable. Two speed modes set the length of the half-bit and of the gap. The 32nd bit can carry a computed parity bit (odd or even) or the word's own top bit. A null-force control silences the lines, and a mirror pair of loopback outputs copies the stream for an on-chip receiver.

Top module: `rz_word_tx`

## Requirements
- R1: Line encoding is A=1,B=0 for a one, A=0,B=1 for a zero, and A=0,B=0 for null. A=1,B=1 never appears.
- R2: Word bit 0 is sent first and the word's bits follow in ascending order. The first bit's level is on the lines in the clock cycle right after the word is accepted, which is well within 2.5 reference ticks.
- R3: In fast mode (`slow_mode`=0), each bit drives its level for 5 ticks and then null for 5 ticks. The inter-word gap is 40 ticks of null.
- R4: In slow mode (`slow_mode`=1), each bit drives its level for 40 ticks and then null for 40 ticks. The inter-word gap is 320 ticks of null.
- R5: When `par_en`=1, the 32nd bit sent is computed from word bits 30..0. With `par_even`=0 it makes the total number of ones across all 32 bits odd. With `par_even`=1 it makes that total even.
- R6: When `par_en`=0, the 32nd bit sent is word bit 31, unchanged.
- R7: A word is taken on a clock edge where `word_valid` and `word_ready` are both high. `word_ready` stays low from acceptance until the gap ends. `done` is high for exactly one cycle at the end of the gap, and `word_ready` returns high at the same time.
- R8: When `force_null`=1, both lines and both loopback outputs are null from the next clock onward. The word keeps its timing underneath.
- R9: When `loop_off`=0 and `force_null`=0, `lb_a`/`lb_b` equal the stream on the lines. When `loop_off`=1, the loopback pair is null and the lines are unaffected.
- R10: Speed mode and parity settings are captured when a word is accepted. Changing them during a word has no effect until the next word.
- R11: Synchronous reset aborts any word. After reset, both lines and both loopback outputs are null, `done` is 0 and `word_ready` is 1.
- R12: Symbol timing advances only on clock cycles where `tick` is high. Cycles without a tick leave the lines unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | 1 MHz reference enable, one clock wide |
| word_valid | input | 1 | Source offers a word |
| word_data | input | 32 | Word to send, bit 0 first |
| word_ready | output | 1 | Serializer idle and able to take a word |
| slow_mode | input | 1 | 0 = fast timing, 1 = slow timing |
| par_en | input | 1 | 1 = bit 32 is computed parity |
| par_even | input | 1 | Parity sense: 0 odd, 1 even |
| loop_off | input | 1 | 1 = loopback outputs held null |
| force_null | input | 1 | 1 = lines and loopback held null |
| line_a | output | 1 | Line A level |
| line_b | output | 1 | Line B level |
| lb_a | output | 1 | Loopback copy of line A |
| lb_b | output | 1 | Loopback copy of line B |
| done | output | 1 | One-cycle pulse at end of inter-word gap |

## Verification
The stream is driven with all-zero, all-one, alternating and edge-bit words under each parity setting. Those patterns separate a wrong bit order, a wrong parity sense and a missing parity bypass. Words are sent in both speed modes, with the reference tick either held high or dropped irregularly, which checks that half-bit and gap lengths count ticks rather than clocks. The speed mode and the parity settings are toggled mid-word to show they are captured at acceptance, and the null-force and loopback controls are toggled mid-word to show they act only on the outputs. Back-to-back words and a reset in the middle of a word exercise the handshake and the abort.

// File: rtl/rzt_pkg.sv
package rzt_pkg;
  typedef enum logic [1:0] {
    SYM_NULL = 2'd0,
    SYM_ONE  = 2'd1,
    SYM_ZERO = 2'd2
  } sym_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DATA = 2'd1,
    PH_REST = 2'd2,
    PH_GAP  = 2'd3
  } phase_t;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rzt_parity.sv
module rzt_parity #(
  parameter int W = 32
) (
  input  logic [W-1:0] word_in,
  input  logic         par_en,
  input  logic         par_even,
  output logic         top_bit
);
  localparam int LOW_W = W - 1;

  logic low_xor;

  // Ones count parity of the low W-1 bits
  assign low_xor = ^word_in[LOW_W-1:0];

  // Odd sense: top bit set when low ones are even; even sense: copy low parity
  always_comb begin
    if (par_en) top_bit = par_even ? low_xor : ~low_xor;
    else        top_bit = word_in[W-1];
  end
endmodule

// File: rtl/rzt_seq.sv
module rzt_seq
  import rzt_pkg::*;
#(
  parameter int W       = 32,
  parameter int HI_HALF = 5,
  parameter int LO_HALF = 40,
  parameter int HI_GAP  = 40,
  parameter int LO_GAP  = 320
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         word_valid,
  input  logic [W-1:0] word_data,
  input  logic         top_bit,
  input  logic         slow_mode,
  output logic         word_ready,
  output sym_t         sym_nxt,
  output logic         done_nxt
);
  localparam int MAXL = max_of(max_of(HI_HALF, LO_HALF), max_of(HI_GAP, LO_GAP));
  localparam int CW   = $clog2(MAXL + 1);
  localparam int IW   = $clog2(W);
  localparam logic [IW-1:0] LAST_IDX = IW'(W - 1);
  localparam logic [CW-1:0] HI_HALF_M1 = CW'(HI_HALF - 1);
  localparam logic [CW-1:0] LO_HALF_M1 = CW'(LO_HALF - 1);
  localparam logic [CW-1:0] HI_GAP_M1  = CW'(HI_GAP - 1);
  localparam logic [CW-1:0] LO_GAP_M1  = CW'(LO_GAP - 1);

  phase_t          ph_q, ph_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [IW-1:0]   idx_q, idx_d;
  logic [W-1:0]    sh_q, sh_d;
  logic            slow_q, slow_d;
  logic [CW-1:0]   half_m1, gap_m1, lim_m1;
  logic            at_end;

  assign half_m1 = slow_q ? LO_HALF_M1 : HI_HALF_M1;
  assign gap_m1  = slow_q ? LO_GAP_M1  : HI_GAP_M1;
  assign lim_m1  = (ph_q == PH_GAP) ? gap_m1 : half_m1;
  assign at_end  = tick && (cnt_q == lim_m1);

  assign word_ready = (ph_q == PH_IDLE);

  always_comb begin
    ph_d     = ph_q;
    cnt_d    = cnt_q;
    idx_d    = idx_q;
    sh_d     = sh_q;
    slow_d   = slow_q;
    done_nxt = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (word_valid) begin
          ph_d   = PH_DATA;
          cnt_d  = '0;
          idx_d  = '0;
          sh_d   = {top_bit, word_data[W-2:0]};
          slow_d = slow_mode;
        end
      end
      PH_DATA: begin
        if (at_end) begin
          ph_d  = PH_REST;
          cnt_d = '0;
        end else if (tick) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_REST: begin
        if (at_end) begin
          cnt_d = '0;
          if (idx_q == LAST_IDX) begin
            ph_d = PH_GAP;
          end else begin
            ph_d  = PH_DATA;
            idx_d = idx_q + 1'b1;
            sh_d  = {1'b0, sh_q[W-1:1]};
          end
        end else if (tick) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_GAP: begin
        if (at_end) begin
          ph_d     = PH_IDLE;
          cnt_d    = '0;
          done_nxt = 1'b1;
        end else if (tick) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_comb begin
    if (ph_d == PH_DATA) sym_nxt = sh_d[0] ? SYM_ONE : SYM_ZERO;
    else                 sym_nxt = SYM_NULL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      slow_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      slow_q <= slow_d;
    end
  end
endmodule

// File: rtl/rzt_line_enc.sv
module rzt_line_enc
  import rzt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  sym_t sym_nxt,
  input  logic done_nxt,
  input  logic force_null,
  input  logic loop_off,
  output logic line_a,
  output logic line_b,
  output logic lb_a,
  output logic lb_b,
  output logic done
);
  logic a_nxt, b_nxt, lb_en;

  assign a_nxt = (sym_nxt == SYM_ONE)  && !force_null;
  assign b_nxt = (sym_nxt == SYM_ZERO) && !force_null;
  assign lb_en = !loop_off && !force_null;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_a <= 1'b0;
      line_b <= 1'b0;
      lb_a   <= 1'b0;
      lb_b   <= 1'b0;
      done   <= 1'b0;
    end else begin
      line_a <= a_nxt;
      line_b <= b_nxt;
      lb_a   <= a_nxt && lb_en;
      lb_b   <= b_nxt && lb_en;
      done   <= done_nxt;
    end
  end
endmodule

// File: rtl/rz_word_tx.sv
module rz_word_tx
  import rzt_pkg::*;
#(
  parameter int W       = 32,
  parameter int HI_HALF = 5,
  parameter int LO_HALF = 40,
  parameter int HI_GAP  = 40,
  parameter int LO_GAP  = 320
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         word_valid,
  input  logic [W-1:0] word_data,
  output logic         word_ready,
  input  logic         slow_mode,
  input  logic         par_en,
  input  logic         par_even,
  input  logic         loop_off,
  input  logic         force_null,
  output logic         line_a,
  output logic         line_b,
  output logic         lb_a,
  output logic         lb_b,
  output logic         done
);
  logic top_bit;
  sym_t sym_nxt;
  logic done_nxt;

  rzt_parity #(.W(W)) u_par (
    .word_in  (word_data),
    .par_en   (par_en),
    .par_even (par_even),
    .top_bit  (top_bit)
  );

  rzt_seq #(
    .W(W), .HI_HALF(HI_HALF), .LO_HALF(LO_HALF), .HI_GAP(HI_GAP), .LO_GAP(LO_GAP)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .word_valid (word_valid),
    .word_data  (word_data),
    .top_bit    (top_bit),
    .slow_mode  (slow_mode),
    .word_ready (word_ready),
    .sym_nxt    (sym_nxt),
    .done_nxt   (done_nxt)
  );

  rzt_line_enc u_enc (
    .clk        (clk),
    .rst        (rst),
    .sym_nxt    (sym_nxt),
    .done_nxt   (done_nxt),
    .force_null (force_null),
    .loop_off   (loop_off),
    .line_a     (line_a),
    .line_b     (line_b),
    .lb_a       (lb_a),
    .lb_b       (lb_b),
    .done       (done)
  );
endmodule

// File: rtl/rzt_checker.sv
module rzt_checker (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic word_valid,
  input logic word_ready,
  input logic loop_off,
  input logic force_null,
  input logic line_a,
  input logic line_b,
  input logic lb_a,
  input logic lb_b,
  input logic done
);
  p_no_both_r1: assert property (@(posedge clk) disable iff (rst)
    !(line_a && line_b));

  p_first_bit_r2: assert property (@(posedge clk) disable iff (rst)
    (word_valid && word_ready && !force_null) |=> (line_a || line_b));

  p_busy_after_take_r7: assert property (@(posedge clk) disable iff (rst)
    (word_valid && word_ready) |=> !word_ready);

  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_ready_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> word_ready);

  p_forced_null_r8: assert property (@(posedge clk) disable iff (rst)
    $past(force_null) |-> (!line_a && !line_b && !lb_a && !lb_b));

  p_loop_mirror_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(loop_off) && !$past(force_null)) |-> (lb_a == line_a && lb_b == line_b));

  p_loop_null_r9: assert property (@(posedge clk) disable iff (rst)
    $past(loop_off) |-> (!lb_a && !lb_b));

  p_hold_no_tick_r12: assert property (@(posedge clk) disable iff (rst)
    (!word_ready && !tick && (force_null == $past(force_null)))
      |=> ($stable(line_a) && $stable(line_b)));
endmodule

bind rz_word_tx rzt_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick       (tick),
  .word_valid (word_valid),
  .word_ready (word_ready),
  .loop_off   (loop_off),
  .force_null (force_null),
  .line_a     (line_a),
  .line_b     (line_b),
  .lb_a       (lb_a),
  .lb_b       (lb_b),
  .done       (done)
);

// File: tb/tb_rz_word_tx.sv
module tb_rz_word_tx;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        word_valid = 1'b0;
  logic [31:0] word_data = '0;
  logic        word_ready;
  logic        slow_mode = 1'b0;
  logic        par_en = 1'b0;
  logic        par_even = 1'b0;
  logic        loop_off = 1'b0;
  logic        force_null = 1'b0;
  logic        line_a, line_b, lb_a, lb_b, done;

  rz_word_tx dut (
    .clk(clk), .rst(rst), .tick(tick), .word_valid(word_valid), .word_data(word_data),
    .word_ready(word_ready), .slow_mode(slow_mode), .par_en(par_en), .par_even(par_even),
    .loop_off(loop_off), .force_null(force_null), .line_a(line_a), .line_b(line_b),
    .lb_a(lb_a), .lb_b(lb_b), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cycles = 0;
  bit    started = 0;
  bit    finished = 0;
  int    tick_mode = 0;
  string cur_req = "R11";

  // Reference model: one queue entry per reference tick (0 null, 1 one, 2 zero)
  int   q[$];
  int   cur = 0;
  logic e_a = 0, e_b = 0, e_la = 0, e_lb = 0, e_done = 0, e_ready = 1;

  function automatic void build_word(input logic [31:0] w, input bit slow, input bit pe, input bit ev);
    int half = slow ? 40 : 5;
    int gap  = slow ? 320 : 40;
    int ones = 0;
    bit b32;
    for (int i = 0; i < 31; i++) ones += w[i];
    if (pe) b32 = ev ? (ones % 2 == 1) : (ones % 2 == 0);
    else    b32 = w[31];
    for (int i = 0; i < 32; i++) begin
      bit bv = (i == 31) ? b32 : w[i];
      for (int k = 0; k < half; k++) q.push_back(bv ? 1 : 2);
      for (int k = 0; k < half; k++) q.push_back(0);
    end
    for (int k = 0; k < gap; k++) q.push_back(0);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      q.delete();
      cur = 0;
      e_done = 0;
      e_ready = 1;
    end else begin
      e_done = 0;
      if (q.size() == 0) begin
        if (word_valid) begin
          build_word(word_data, slow_mode, par_en, par_even);
          cur = q[0];
        end else begin
          cur = 0;
        end
      end else if (tick) begin
        void'(q.pop_front());
        if (q.size() == 0) begin
          e_done = 1;
          cur = 0;
        end else begin
          cur = q[0];
        end
      end
      e_ready = (q.size() == 0);
    end
    e_a  = !rst && !force_null && cur == 1;
    e_b  = !rst && !force_null && cur == 2;
    e_la = e_a && !loop_off;
    e_lb = e_b && !loop_off;
    started = 1;
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, what, cycles, act, exp);
    end
  endtask

  // Compare every clock, away from the active edge
  always @(negedge clk) begin
    if (started && !finished) begin
      chk(cur_req, "line_a", line_a, e_a);
      chk(cur_req, "line_b", line_b, e_b);
      chk(cur_req, "lb_a", lb_a, e_la);
      chk(cur_req, "lb_b", lb_b, e_lb);
      chk(cur_req, "done", done, e_done);
      chk(cur_req, "word_ready", word_ready, e_ready);
      chk("R1", "both lines high", line_a && line_b, 1'b0);
    end
    if (tick_mode == 0) tick = 1'b1;
    else                tick = ($urandom % 3) != 0;
  end

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    while (!word_ready) @(negedge clk);
    word_data  = w;
    word_valid = 1'b1;
    @(negedge clk);
    word_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!word_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > WATCHDOG && !finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11: state right after reset
    @(negedge clk);
    chk("R11", "ready after reset", word_ready, 1'b1);
    chk("R11", "lines null after reset", line_a | line_b, 1'b0);

    // R1 R2 R3 R6: fast mode, parity bypassed, distinct patterns
    cur_req = "R2";
    send(32'h0000_0001);
    chk("R2", "bit 0 first on line_a", line_a, 1'b1);
    wait_idle();
    cur_req = "R6";
    send(32'h8000_0000);
    wait_idle();
    cur_req = "R3";
    send(32'hA5A5_5A5A);
    wait_idle();

    // R5: parity odd / even on several patterns
    par_en = 1'b1;
    cur_req = "R5";
    par_even = 1'b0; send(32'h0000_0000); wait_idle();
    par_even = 1'b1; send(32'hFFFF_FFFF); wait_idle();
    par_even = 1'b0; send(32'h7FFF_FFFE); wait_idle();
    par_even = 1'b1; send(32'h1234_5678); wait_idle();

    // R12: irregular tick
    cur_req = "R12";
    tick_mode = 1;
    send(32'hC0FF_EE01);
    wait_idle();

    // R7: words back to back
    cur_req = "R7";
    send(32'h0F0F_0F0F);
    send(32'hF0F0_F0F1);
    wait_idle();

    // R8 R9: output controls toggled mid word
    cur_req = "R9";
    send(32'h5555_AAAA);
    repeat (37) @(negedge clk);
    loop_off = 1'b1;
    repeat (61) @(negedge clk);
    cur_req = "R8";
    force_null = 1'b1;
    repeat (45) @(negedge clk);
    force_null = 1'b0;
    loop_off = 1'b0;
    wait_idle();

    // R4 R10: slow mode, settings flipped mid word
    cur_req = "R4";
    slow_mode = 1'b1;
    send(32'h9696_3C3C);
    repeat (200) @(negedge clk);
    cur_req = "R10";
    slow_mode = 1'b0;
    par_even = 1'b0;
    par_en = 1'b0;
    wait_idle();
    send(32'h0000_FFFF);
    repeat (30) @(negedge clk);
    slow_mode = 1'b1;
    par_en = 1'b1;
    wait_idle();
    slow_mode = 1'b0;

    // R11: reset in the middle of a word
    cur_req = "R11";
    send(32'hDEAD_BEEF);
    repeat (50) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11", "ready after mid-word reset", word_ready, 1'b1);
    chk("R11", "done after mid-word reset", done, 1'b0);
    chk("R11", "line_b after mid-word reset", line_b, 1'b0);
    send(32'h0000_0002);
    chk("R2", "first bit zero drives line_b", line_b, 1'b1);
    wait_idle();

    finish_run();
  end
endmodule